// File: doc/BRIEF.md
# Branch Target Buffer

This block is a small direct-mapped cache that the fetch stage looks up with the current fetch address before the instruction is decoded. In the same cycle it reports whether that address is a known taken branch and what the next fetch address should be. On a hit the stored target is returned, so a correctly predicted taken branch costs no cycles. On a miss fetch falls through to the sequential address, which is the default not-taken prediction.

When a branch resolves, the pipeline presents the branch address, its real target and whether it was taken on the update port. A taken outcome installs or overwrites the entry. A not-taken outcome whose entry is present demotes that entry, so later lookups fall through. Each entry holds a valid bit, an address tag, a full target address and a taken bit. The entry index is taken from the address bits just above the word offset, and the tag is made of all bits above the index.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid: each lookup gives hit_o = 0 and next_pc_o = pc_i + 4.
- R2: hit_o is 1 only when the indexed entry is valid, its tag equals the lookup tag and its taken bit is set. In that cycle next_pc_o is the stored target, with no register between pc_i and the outputs.
- R3: Whenever hit_o is 0, next_pc_o equals pc_i + 4 (modulo 2^PC_W).
- R4: The index is pc[2 +: log2(ENTRIES)] and the tag is all bits above it. Two addresses with the same index and different tags share one entry, and only the one whose tag is stored can hit. The two lowest address bits select neither the index nor the tag.
- R5: An update with upd_valid_i = 1 and upd_taken_i = 1 writes valid, tag, target and taken into the indexed entry, overwriting any previous owner. From the next cycle a lookup of that address hits with that target.
- R6: An update with upd_taken_i = 0 whose indexed entry is valid with a matching tag clears that entry's taken bit. From the next cycle a lookup of that address misses.
- R7: An update with upd_taken_i = 0 whose indexed entry does not match changes no entry.
- R8: A lookup in the same cycle as an update to the same entry returns the contents from before the update.
- R9: While upd_valid_i = 0, the other update inputs change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | PC_W | Fetch address to look up |
| hit_o | output | 1 | Address is a stored taken branch |
| next_pc_o | output | PC_W | Predicted next fetch address |
| upd_valid_i | input | 1 | Resolved-branch update strobe |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_target_i | input | PC_W | Actual target of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
The bench aims at aliasing. Two addresses that share an index but have different tags fight over one entry. A design that indexes or tags with the wrong bits either lets the evicted address keep hitting or makes the new owner miss. It also presents a not-taken update with a tag that does not match, which a design that skips the tag compare would wrongly apply by clearing the entry of another branch. Lookups in the same cycle as a write to the same entry must return the old contents, which catches a write path bypassed into the read. Updates with the strobe low must not change any entry. A long stretch of seeded random updates and lookups over a small address pool, checked against a model of the buffer in the bench, covers the remaining mixes.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_WRITE = 2'd1,
    UPD_CLEAR = 2'd2
  } upd_act_e;
endpackage

// File: rtl/btb_split.sv
module btb_split #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 2,
  parameter int IDX_W = 4,
  localparam int TAG_W = PC_W - IDX_W - OFF_W
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = pc_i[OFF_W +: IDX_W];
  assign tag_o = pc_i[PC_W-1 -: TAG_W];
endmodule

// File: rtl/btb_upd_dec.sv
module btb_upd_dec
  import btb_pkg::*;
(
  input  logic     upd_valid_i,
  input  logic     upd_taken_i,
  input  logic     match_i,
  output upd_act_e act_o
);
  always_comb begin
    act_o = UPD_NONE;
    if (upd_valid_i) begin
      if (upd_taken_i)  act_o = UPD_WRITE;
      else if (match_i) act_o = UPD_CLEAR;
    end
  end
endmodule

// File: rtl/btb_array.sv
module btb_array
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  upd_act_e         act_i,
  input  logic [IDX_W-1:0] w_idx_i,
  input  logic [TAG_W-1:0] w_tag_i,
  input  logic [PC_W-1:0]  w_tgt_i,
  input  logic [IDX_W-1:0] r_idx_i,
  output logic             r_vld_o,
  output logic             r_tk_o,
  output logic [TAG_W-1:0] r_tag_o,
  output logic [PC_W-1:0]  r_tgt_o,
  output logic             m_vld_o,
  output logic [TAG_W-1:0] m_tag_o
);
  logic [ENTRIES-1:0] vld_q, tk_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = (w_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tk_q[g]  <= 1'b0;
      end else if (sel) begin
        if (act_i == UPD_WRITE) begin
          vld_q[g] <= 1'b1;
          tk_q[g]  <= 1'b1;
        end else if (act_i == UPD_CLEAR) begin
          tk_q[g]  <= 1'b0;
        end
      end
    end

    // payload needs no reset: qualified by vld_q
    always_ff @(posedge clk_i) begin
      if (sel && act_i == UPD_WRITE) begin
        tag_q[g] <= w_tag_i;
        tgt_q[g] <= w_tgt_i;
      end
    end
  end

  assign r_vld_o = vld_q[r_idx_i];
  assign r_tk_o  = tk_q[r_idx_i];
  assign r_tag_o = tag_q[r_idx_i];
  assign r_tgt_o = tgt_q[r_idx_i];
  assign m_vld_o = vld_q[w_idx_i];
  assign m_tag_o = tag_q[w_idx_i];

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == UPD_NONE |=> $stable(vld_q) && $stable(tk_q)); // R9
  AST_ONE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones((vld_q ^ $past(vld_q)) | (tk_q ^ $past(tk_q))) <= 1); // R5
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 16,
  parameter int INSTR_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_i,
  output logic            hit_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_target_i,
  input  logic            upd_taken_i
);
  localparam int OFF_W = $clog2(INSTR_BYTES);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - OFF_W;

  logic [IDX_W-1:0] l_idx, u_idx;
  logic [TAG_W-1:0] l_tag, u_tag;
  logic             r_vld, r_tk, m_vld, u_match;
  logic [TAG_W-1:0] r_tag, m_tag;
  logic [PC_W-1:0]  r_tgt;
  upd_act_e         act;

  btb_split #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_split_look (
    .pc_i(pc_i), .idx_o(l_idx), .tag_o(l_tag));
  btb_split #(.PC_W(PC_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_split_upd (
    .pc_i(upd_pc_i), .idx_o(u_idx), .tag_o(u_tag));

  assign u_match = m_vld && (m_tag == u_tag);

  btb_upd_dec i_dec (
    .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
    .match_i(u_match), .act_o(act));

  btb_array #(.PC_W(PC_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act),
    .w_idx_i(u_idx), .w_tag_i(u_tag), .w_tgt_i(upd_target_i),
    .r_idx_i(l_idx), .r_vld_o(r_vld), .r_tk_o(r_tk), .r_tag_o(r_tag),
    .r_tgt_o(r_tgt), .m_vld_o(m_vld), .m_tag_o(m_tag));

  assign hit_o     = r_vld && r_tk && (r_tag == l_tag);
  assign next_pc_o = hit_o ? r_tgt : pc_i + PC_W'(INSTR_BYTES);

  AST_TAKEN_INSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      (pc_i != $past(upd_pc_i)) || (hit_o && next_pc_o == $past(upd_target_i))); // R5
  AST_NT_DEMOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |=> (pc_i != $past(upd_pc_i)) || !hit_o); // R6
  AST_MISS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> next_pc_o == pc_i + PC_W'(INSTR_BYTES)); // R3
endmodule

// File: tb/test_branch_target_buffer.sv
`timescale 1ns/1ps
module test_branch_target_buffer;
  localparam int PC_W = 32, ENTRIES = 16, IW = 4, OW = 2;

  logic            clk = 0, rst_n = 0;
  logic [PC_W-1:0] pc = 0, upd_pc = 0, upd_tgt = 0;
  logic            upd_v = 0, upd_tk = 0;
  logic            hit;
  logic [PC_W-1:0] nxt;
  int checks = 0, errors = 0;
  bit done = 0;

  logic            m_vld [ENTRIES];
  logic            m_tk  [ENTRIES];
  logic [PC_W-1:0] m_pc  [ENTRIES];
  logic [PC_W-1:0] m_tgt [ENTRIES];

  always #4 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .ENTRIES(ENTRIES)) i_branch_target_buffer (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .hit_o(hit), .next_pc_o(nxt),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_target_i(upd_tgt),
    .upd_taken_i(upd_tk));

  function automatic int ix(logic [PC_W-1:0] a); return int'(a[OW +: IW]); endfunction
  function automatic logic same_tag(logic [PC_W-1:0] a, logic [PC_W-1:0] b);
    return a[PC_W-1:OW+IW] == b[PC_W-1:OW+IW];
  endfunction
  function automatic logic exp_hit(logic [PC_W-1:0] a);
    return m_vld[ix(a)] && m_tk[ix(a)] && same_tag(m_pc[ix(a)], a);
  endfunction
  function automatic logic [PC_W-1:0] exp_next(logic [PC_W-1:0] a);
    return exp_hit(a) ? m_tgt[ix(a)] : a + 4;
  endfunction

  task automatic check(string req);
    checks++;
    if (hit !== exp_hit(pc) || nxt !== exp_next(pc)) begin
      errors++;
      $display("FAIL %s pc=%h hit=%b next=%h expected hit=%b next=%h",
               req, pc, hit, nxt, exp_hit(pc), exp_next(pc));
    end
  endtask

  // drive at negedge, check before the edge (old contents), then update model
  task automatic step(input logic v, input logic [PC_W-1:0] up, input logic [PC_W-1:0] ut,
                      input logic tk, input logic [PC_W-1:0] lk, input string req);
    @(negedge clk);
    upd_v = v; upd_pc = up; upd_tgt = ut; upd_tk = tk; pc = lk;
    #1 check(req);
    @(posedge clk);
    if (v) begin
      if (tk) begin
        m_vld[ix(up)] = 1; m_tk[ix(up)] = 1; m_pc[ix(up)] = up; m_tgt[ix(up)] = ut;
      end else if (m_vld[ix(up)] && same_tag(m_pc[ix(up)], up)) begin
        m_tk[ix(up)] = 0;
      end
    end
  endtask

  task automatic look(input logic [PC_W-1:0] lk, input string req);
    step(0, 32'h0, 32'h0, 0, lk, req);
  endtask

  localparam logic [PC_W-1:0] PA = 32'h0000_1024; // idx 9
  localparam logic [PC_W-1:0] PB = 32'h0000_3024; // idx 9, other tag
  localparam logic [PC_W-1:0] TA = 32'h0000_4000;
  localparam logic [PC_W-1:0] TB = 32'h0000_8880;

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_vld[i] = 0; m_tk[i] = 0; m_pc[i] = 0; m_tgt[i] = 0; end
    void'($urandom(32'd20240611));
    #20 rst_n = 1;
    // R1: empty after reset
    look(PA, "R1"); look(32'hFFFF_FFFC, "R1 wrap"); look(32'h0, "R1");
    // R8: same-cycle lookup sees old contents; R5/R2 hit next cycle
    step(1, PA, TA, 1, PA, "R8");
    look(PA, "R5 R2");
    look(PA | 32'h3, "R4 offset bits");
    // R4: alias misses
    look(PB, "R4 alias");
    // R5 overwrite by alias
    step(1, PB, TB, 1, PB, "R8 overwrite");
    look(PB, "R5 overwrite");
    look(PA, "R4 evicted");
    // R7: non-matching not-taken changes nothing
    step(1, PA, 32'h0, 0, PB, "R7");
    look(PB, "R7");
    // R9: strobe low ignored
    step(0, PB, TA, 0, PB, "R9");
    step(0, 32'h0000_0010, TA, 1, 32'h0000_0010, "R9");
    look(PB, "R9"); look(32'h0000_0010, "R9");
    // R6: matching not-taken demotes
    step(1, PB, 32'h0, 0, PB, "R8 demote");
    look(PB, "R6");
    look(PB + 4, "R3");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0] up, lk, ut;
      up = PC_W'(($urandom % 64) << 2) | 32'h0001_0000;
      lk = ($urandom % 3 == 0) ? up : (PC_W'(($urandom % 64) << 2) | 32'h0001_0000);
      ut = $urandom & 32'hFFFF_FFFC;
      step($urandom % 2 == 0, up, ut, $urandom % 3 != 0, lk, "R2 R3 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule